// File: doc/BRIEF.md
# Serial Command DAC Controller

This block drives a single-channel 12-bit digital-to-analog converter over three wires: an active-low load/select line, a serial clock and a serial data line. A host hands it a 4-bit command and a 12-bit code through a valid/ready handshake. The controller packs them into a 24-bit frame and shifts the frame out MSB first. The converter samples each bit on a rising serial clock edge. When all 24 bits have gone out, the controller raises the load line, and the converter executes the command on that edge.

After reset the controller can optionally send one frame on its own, before it takes any host request. That frame selects the supply rail as the converter's reference. The serial clock is derived from the system clock by a parameterized divider. This keeps its rate within the converter's 50 MHz limit.

Top module: `dac_spi_cmd_ctrl`

## Requirements
- R1: A host request with command `c` and code `k` produces the 24-bit frame {c[3:0], 4'b0000, k[11:0], 4'b0000}, transmitted MSB first. For example, command 0011 with code 0xB39 gives 0x30B390.
- R2: Each frame consists of exactly 24 rising serial clock edges while the load line is low. The first data bit is valid at the first rising edge after the load line falls.
- R3: The load line rises only after the 24th rising edge and the falling edge that follows it, which ends the frame.
- R4: For the reference-select commands 0110 and 0111, the 20 bits after the command nibble are driven as 0, whatever the code input holds.
- R5: With INIT_SUPPLY_REF = 1, the first frame after reset is 0x700000 (command 0111). req_ready stays 0 until that frame has finished.
- R6: While reset is held, dac_ld_n = 1, dac_sck = 0, dac_sdi = 0 and req_ready = 0.
- R7: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the frame and the gap after it are complete. A request held during that time is sent afterwards, unchanged, as the next frame.
- R8: The serial clock period is exactly 2*HALF_CYC system clocks, and dac_sck is 0 whenever dac_ld_n is 1.
- R9: dac_ld_n stays high for at least 2*HALF_CYC system clocks (one serial clock period) between frames.
- R10: dac_sdi changes only while dac_sck is low, so it is stable across every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_cmd | input | 4 | Command nibble |
| req_code | input | 12 | 12-bit converter code |
| dac_ld_n | output | 1 | Active-low select; its rising edge executes the command |
| dac_sck | output | 1 | Serial clock; the converter samples on rising edges |
| dac_sdi | output | 1 | Serial data, MSB first |

## Verification
The assertions assume that the host holds req_cmd and req_code steady in any cycle where it raises req_valid while req_ready is high. They also assume that reset is applied for at least one clock before operation. The bench drives requests only at the falling system clock edge, after it has seen req_ready high. It holds the data until the next falling edge, so every transfer lands on one well-defined rising edge. A deliberately held-off request keeps its data stable until it is taken.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int FRAME_W = 24;
  localparam int CMD_W   = 4;
  localparam int CODE_W  = 12;
  localparam int PAD_W   = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_WRITE        = 4'h0,
    CMD_UPDATE       = 4'h1,
    CMD_WRITE_UPDATE = 4'h3,
    CMD_POWER_DOWN   = 4'h4,
    CMD_REF_INTERNAL = 4'h6,
    CMD_REF_SUPPLY   = 4'h7
  } dac_cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_SHIFT,
    ST_END,
    ST_GAP
  } ctl_state_e;

  // Builds the serial frame; reference selects carry an all-zero payload.
  function automatic logic [FRAME_W-1:0] pack_frame(logic [CMD_W-1:0] cmd,
                                                    logic [CODE_W-1:0] code);
    if (cmd == CMD_REF_INTERNAL || cmd == CMD_REF_SUPPLY)
      return {cmd, {(FRAME_W-CMD_W){1'b0}}};
    return {cmd, {PAD_W{1'b0}}, code, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dac_spi_tick.sv
module dac_spi_tick #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R8: the half-period counter never passes its limit
  a_r8_tick_bound: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < HALF_CYC);
endmodule

// File: rtl/dac_spi_shreg.sv
module dac_spi_shreg #(
  parameter int FRAME_W = 24,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise,
  input  logic               fall,
  output logic               sdi,
  output logic [CNT_W-1:0]   bit_cnt
);
  logic [FRAME_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      sreg    <= frame_in;
      bit_cnt <= '0;
    end else begin
      if (fall) sreg <= {sreg[FRAME_W-2:0], 1'b0};
      if (rise) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign sdi = sreg[FRAME_W-1];

  // R2: no more than one frame's worth of rising edges is counted
  a_r2_cnt_limit: assert property (@(posedge clk) disable iff (rst)
    32'(bit_cnt) <= FRAME_W);
  // R10: data moves only on a falling-edge request, never with a rising one
  a_r10_no_shift_on_rise: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
endmodule

// File: rtl/dac_spi_cmd_ctrl.sv
module dac_spi_cmd_ctrl #(
  parameter int       HALF_CYC        = 2,
  parameter bit       INIT_SUPPLY_REF = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_cmd,
  input  logic [11:0] req_code,
  output logic        dac_ld_n,
  output logic        dac_sck,
  output logic        dac_sdi
);
  import dac_spi_pkg::*;

  localparam int CNT_W = $clog2(FRAME_W + 1);

  ctl_state_e         state;
  logic               tick, tick_en, fire, load, rise_p, fall_p;
  logic               gap_cnt;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] frame_sel;

  assign fire      = req_valid && req_ready;
  assign load      = fire || (state == ST_BOOT && INIT_SUPPLY_REF);
  assign frame_sel = (state == ST_BOOT) ? pack_frame(CMD_REF_SUPPLY, '0)
                                        : pack_frame(req_cmd, req_code);
  assign tick_en   = (state == ST_SHIFT) || (state == ST_END) || (state == ST_GAP);
  assign rise_p    = (state == ST_SHIFT) && tick && !dac_sck;
  assign fall_p    = (state == ST_SHIFT) && tick && dac_sck &&
                     (bit_cnt != CNT_W'(FRAME_W));

  dac_spi_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (tick_en),
    .tick(tick)
  );

  dac_spi_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .frame_in(frame_sel),
    .rise    (rise_p),
    .fall    (fall_p),
    .sdi     (dac_sdi),
    .bit_cnt (bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BOOT;
      dac_ld_n  <= 1'b1;
      dac_sck   <= 1'b0;
      req_ready <= 1'b0;
      gap_cnt   <= 1'b0;
    end else begin
      case (state)
        ST_BOOT: begin
          if (INIT_SUPPLY_REF) begin
            dac_ld_n <= 1'b0;
            state    <= ST_SHIFT;
          end else begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (fire) begin
            req_ready <= 1'b0;
            dac_ld_n  <= 1'b0;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!dac_sck) dac_sck <= 1'b1;
            else begin
              dac_sck <= 1'b0;
              if (bit_cnt == CNT_W'(FRAME_W)) state <= ST_END;
            end
          end
        end
        ST_END: begin
          if (tick) begin
            dac_ld_n <= 1'b1;
            gap_cnt  <= 1'b0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_cnt) begin
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end else gap_cnt <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the load line rises only after a full frame was clocked
  a_r3_ld_rise_full: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_ld_n) |-> bit_cnt == CNT_W'(FRAME_W));
  // R8: the serial clock rests low outside a frame
  a_r8_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    dac_ld_n |-> !dac_sck);
  // R10: data is stable while the serial clock is high
  a_r10_sdi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (dac_sck && $past(dac_sck)) |-> $stable(dac_sdi));
  // R7: ready only while the line is idle
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dac_ld_n && !dac_sck));
  // R7: an accepted request starts a frame and drops ready
  a_r7_accept_starts: assert property (@(posedge clk) disable iff (rst)
    fire |=> (!dac_ld_n && !req_ready));
endmodule

// File: tb/dac_spi_cmd_ctrl_test.sv
module dac_spi_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [3:0] req_cmd = '0;
  logic [11:0] req_code = '0;
  logic req_ready, dac_ld_n, dac_sck, dac_sdi;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_spi_cmd_ctrl #(.HALF_CYC(HALF), .INIT_SUPPLY_REF(1'b1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_code(req_code), .dac_ld_n(dac_ld_n),
    .dac_sck(dac_sck), .dac_sdi(dac_sdi)
  );

  // Receiver model sampled between edges
  logic [23:0] cap, last_frame, prev_frame;
  int cap_bits, last_bits, frames, cyc, rise_cyc, ld_rise_cyc;
  int min_gap, min_per, max_per;
  bit p_ld = 1, p_sck = 0, p_sdi = 0, early_ready = 0, sck_idle_bad = 0, sdi_bad = 0;

  initial begin
    cap = '0; last_frame = '0; prev_frame = '0; cap_bits = 0; last_bits = 0;
    frames = 0; cyc = 0; rise_cyc = 0; ld_rise_cyc = 0;
    min_gap = 1000000; min_per = 1000000; max_per = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (frames == 0 && req_ready) early_ready = 1;
      if (dac_ld_n && dac_sck) sck_idle_bad = 1;
      if (!dac_ld_n && dac_sck && p_sck && dac_sdi != p_sdi) sdi_bad = 1;
      if (p_ld && !dac_ld_n) begin
        cap = '0; cap_bits = 0;
        if (frames > 0 && cyc - ld_rise_cyc < min_gap) min_gap = cyc - ld_rise_cyc;
      end
      if (!dac_ld_n && !p_sck && dac_sck) begin
        cap = {cap[22:0], dac_sdi};
        if (cap_bits > 0) begin
          if (cyc - rise_cyc < min_per) min_per = cyc - rise_cyc;
          if (cyc - rise_cyc > max_per) max_per = cyc - rise_cyc;
        end
        cap_bits++; rise_cyc = cyc;
      end
      if (!p_ld && dac_ld_n) begin
        prev_frame = last_frame; last_frame = cap; last_bits = cap_bits;
        ld_rise_cyc = cyc; frames++;
      end
      p_ld = dac_ld_n; p_sck = dac_sck; p_sdi = dac_sdi;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frames(int n);
    int target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  task automatic send(logic [3:0] c, logic [11:0] k);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_code = k;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_check(logic [3:0] c, logic [11:0] k, logic [23:0] exp, string req);
    send(c, k);
    wait_frames(1);
    chk(req, "frame", last_frame, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R6", "ld_n in reset", dac_ld_n, 1);
    chk("R6", "sck in reset", dac_sck, 0);
    chk("R6", "sdi in reset", dac_sdi, 0);
    chk("R6", "ready in reset", req_ready, 0);
  endtask

  task automatic t_startup;
    wait_frames(1);
    chk("R5", "startup frame", last_frame, 24'h700000);
    chk("R2", "startup bit count", last_bits, 24);
    chk("R5", "ready before startup done", early_ready, 0);
  endtask

  task automatic t_write;
    send_check(4'h3, 12'hB39, 24'h30B390, "R1");
    chk("R3", "bits at load rise", last_bits, 24);
  endtask

  task automatic t_patterns;
    send_check(4'h0, 12'hFFF, 24'h00FFF0, "R1");
    send_check(4'h4, 12'h000, 24'h400000, "R1");
    send_check(4'h1, 12'h5A5, 24'h105A50, "R1");
  endtask

  task automatic t_refsel;
    send_check(4'h6, 12'hABC, 24'h600000, "R4");
    send_check(4'h7, 12'hFFF, 24'h700000, "R4");
  endtask

  task automatic t_handshake;
    int start;
    while (!req_ready) @(negedge clk);
    start = frames;
    req_valid = 1'b1; req_cmd = 4'h3; req_code = 12'h123;
    @(negedge clk);
    chk("R7", "ready after accept", req_ready, 0);
    req_cmd = 4'h0; req_code = 12'h456;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (frames < start + 2) @(negedge clk);
    chk("R7", "first frame", prev_frame, 24'h301230);
    chk("R7", "held frame", last_frame, 24'h004560);
  endtask

  task automatic t_timing;
    chk("R9", "min gap ok", 32'(min_gap >= 2*HALF), 1);
    chk("R8", "min sck period", min_per, 2*HALF);
    chk("R8", "max sck period", max_per, 2*HALF);
    chk("R8", "sck high while idle", sck_idle_bad, 0);
    chk("R10", "sdi moved while sck high", sdi_bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_startup();
    t_write();
    t_patterns();
    t_refsel();
    t_handshake();
    t_timing();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule